// File: doc/BRIEF.md
# Four-Bit Add, Subtract and AND Unit

The block takes two unsigned operands and a two-bit operation code and returns one result word and one flag. A single ripple-carry chain does both addition and two's-complement subtraction: the second operand is inverted bit by bit and a carry-in of one is injected whenever the low code bit asks for subtraction. A bitwise AND unit runs beside the chain. A two-way multiplexer, steered by the high code bit, picks which of the two results is used.

The combinational result and flag go into one output register, which is cleared by an asynchronous active-low reset. A caller presents operands and a code before a rising clock edge and reads the answer after that edge. The operand width is a parameter with a default of four bits.

Top module: `alu4_core`

## Requirements
- R1: While `rst_n` is low, `res` and `flag` are both 0.
- R2: With `ctrl` = 2'b00, `{flag, res}` equals the unsigned sum `opa + opb` taken five bits wide. For example, 8 + 8 gives `res` = 0000 with `flag` = 1, 10 + 10 gives 0100 with `flag` = 1, and 6 + 2 gives 1000 with `flag` = 0.
- R3: With `ctrl` = 2'b01, `res` equals `opa - opb` modulo 16 (two's complement).
- R4: With `ctrl` = 2'b10 or 2'b11, `res` equals `opa & opb`. The low code bit has no effect on either output.
- R5: With `ctrl` = 2'b01, `flag` is the carry out of the top bit. It is 1 exactly when `opa >= opb` as unsigned numbers.
- R6: With `ctrl[1]` = 1, `flag` is 0.
- R7: The inputs are sampled at each rising edge of `clk`, and the outputs change only at that edge. The result for a given sample is therefore visible from that edge until the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register loads on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa | input | 4 | First operand |
| opb | input | 4 | Second operand |
| ctrl | input | 2 | Operation code: 00 add, 01 subtract, 1x AND |
| res | output | 4 | Registered result |
| flag | output | 1 | Registered carry-out flag; 0 in AND mode |

## Verification
Each result and its flag are due exactly one rising edge after the operands and code are applied. The bench drives a new input set on every falling edge, so the value already present on the outputs belongs to the set driven one cycle earlier. At the next falling edge it takes that earlier set's expected value from a queue and compares the outputs against it. Just after each new drive it checks again that the outputs have not moved before the edge. The sweep covers every code with every operand pair.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int ALU_W = 4;

    typedef enum logic [1:0] {
        OP_ADD   = 2'b00,
        OP_SUB   = 2'b01,
        OP_AND_A = 2'b10,
        OP_AND_B = 2'b11
    } alu_op_e;

    // High code bit selects the logic path; low bit only matters for arithmetic.
    function automatic logic op_is_logic(input alu_op_e op);
        return op[1];
    endfunction

    function automatic logic op_is_sub(input alu_op_e op);
        return (op == OP_SUB);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] b_eff;

    assign carry[0] = sub_i;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign b_eff[i]    = b_i[i] ^ sub_i;
            assign sum_o[i]    = a_i[i] ^ b_eff[i] ^ carry[i];
            assign carry[i+1]  = (a_i[i] & b_eff[i]) | (carry[i] & (a_i[i] ^ b_eff[i]));
        end
    endgenerate

    assign cout_o = carry[WIDTH];
endmodule

// File: rtl/alu_and_unit.sv
module alu_and_unit #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] y_o
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign y_o[i] = a_i[i] & b_i[i];
        end
    endgenerate
endmodule

// File: rtl/alu_mux2.sv
module alu_mux2 #(
    parameter int WIDTH = 4
) (
    input  logic             sel_i,
    input  logic [WIDTH-1:0] d0_i,
    input  logic [WIDTH-1:0] d1_i,
    output logic [WIDTH-1:0] y_o
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign y_o[i] = (~sel_i & d0_i[i]) | (sel_i & d1_i[i]);
        end
    endgenerate
endmodule

// File: rtl/alu4_core.sv
module alu4_core
    import alu_pkg::*;
#(
    parameter int WIDTH = ALU_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [1:0]       ctrl,
    output logic [WIDTH-1:0] res,
    output logic             flag
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             flag;
    } out_t;

    alu_op_e          op;
    logic             sub_en;
    logic             sel_logic;
    logic [WIDTH-1:0] arith_sum;
    logic             arith_cout;
    logic [WIDTH-1:0] and_val;
    logic [WIDTH-1:0] mux_val;
    out_t             out_d;
    out_t             out_q;

    assign op        = alu_op_e'(ctrl);
    assign sub_en    = op_is_sub(op);
    assign sel_logic = op_is_logic(op);

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i    (opa),
        .b_i    (opb),
        .sub_i  (sub_en),
        .sum_o  (arith_sum),
        .cout_o (arith_cout)
    );

    alu_and_unit #(.WIDTH(WIDTH)) u_and (
        .a_i (opa),
        .b_i (opb),
        .y_o (and_val)
    );

    alu_mux2 #(.WIDTH(WIDTH)) u_mux (
        .sel_i (sel_logic),
        .d0_i  (arith_sum),
        .d1_i  (and_val),
        .y_o   (mux_val)
    );

    always_comb begin
        out_d      = out_q;
        out_d.res  = mux_val;
        out_d.flag = sel_logic ? 1'b0 : arith_cout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res  = out_q.res;
    assign flag = out_q.flag;
endmodule

// File: rtl/alu4_core_chk.sv
module alu4_core_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [1:0]       ctrl,
    input logic [WIDTH-1:0] res,
    input logic             flag
);
    // Set once an edge has passed with reset released, so $past inputs were captured.
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(ctrl) == 2'b00) |->
        ({flag, res} == ({1'b0, $past(opa)} + {1'b0, $past(opb)})));

    p_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(ctrl) == 2'b01) |->
        (res == WIDTH'($past(opa) - $past(opb))));

    p_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(ctrl[1])) |-> (res == ($past(opa) & $past(opb))));

    p_sub_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(ctrl) == 2'b01) |-> (flag == ($past(opa) >= $past(opb))));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(ctrl[1])) |-> !flag);
endmodule

bind alu4_core alu4_core_chk #(.WIDTH(WIDTH)) u_alu4_core_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .opa   (opa),
    .opb   (opb),
    .ctrl  (ctrl),
    .res   (res),
    .flag  (flag)
);

// File: tb/test_alu4_core.sv
module test_alu4_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] opa = '0;
    logic [3:0] opb = '0;
    logic [1:0] ctrl = '0;
    logic [3:0] res;
    logic       flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // expected {flag,res} and code per driven set
    int q_res[$];
    int q_flg[$];
    int q_op[$];

    always #5 clk = ~clk;

    alu4_core i_alu4_core (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb),
        .ctrl(ctrl), .res(res), .flag(flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, exp, $time);
        end
    endtask

    task automatic model(input int c, input int a, input int b, output int r, output int f);
        if (c >= 2) begin
            r = a & b; f = 0;
        end else if (c == 0) begin
            r = (a + b) % 16; f = (a + b >= 16) ? 1 : 0;
        end else begin
            r = (a - b + 16) % 16; f = (a >= b) ? 1 : 0;
        end
    endtask

    task automatic compare_front();
        int er, ef, eo;
        er = q_res.pop_front(); ef = q_flg.pop_front(); eo = q_op.pop_front();
        if (eo >= 2) begin
            check("R4 and result", int'(res), er);
            check("R6 flag in AND mode", int'(flag), ef);
        end else if (eo == 0) begin
            check("R2 sum", int'({flag, res}), ef * 16 + er);
        end else begin
            check("R3 difference", int'(res), er);
            check("R5 borrow flag", int'(flag), ef);
        end
    endtask

    initial begin
        int er, ef;
        int last_r, last_f;
        // R1: outputs held at zero under reset, even across edges with live inputs
        opa = 4'd9; opb = 4'd7; ctrl = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset res", int'(res), 0);
        check("R1 reset flag", int'(flag), 0);
        rst_n = 1'b1;

        for (int c = 0; c < 4; c++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    @(negedge clk);
                    if (q_res.size() > 0) compare_front();
                    last_r = int'(res); last_f = int'(flag);
                    opa = 4'(a); opb = 4'(b); ctrl = 2'(c);
                    model(c, a, b, er, ef);
                    q_res.push_back(er); q_flg.push_back(ef); q_op.push_back(c);
                    #1;
                    // R7: new inputs do not reach the outputs before the edge
                    check("R7 res holds until edge", int'(res), last_r);
                    check("R7 flag holds until edge", int'(flag), last_f);
                end
            end
        end
        @(negedge clk);
        compare_front();

        // R2 named examples, plus R4 low code bit ignored
        foreach (q_res[i]) begin end
        begin
            int ca[5] = '{0, 0, 0, 2, 3};
            int aa[5] = '{8, 10, 6, 13, 13};
            int bb[5] = '{8, 10, 2, 11, 11};
            for (int k = 0; k < 5; k++) begin
                opa = 4'(aa[k]); opb = 4'(bb[k]); ctrl = 2'(ca[k]);
                model(ca[k], aa[k], bb[k], er, ef);
                q_res.push_back(er); q_flg.push_back(ef); q_op.push_back(ca[k]);
                @(negedge clk);
                compare_front();
            end
        end

        // R1: asynchronous reset clears the register between edges
        #2 rst_n = 1'b0;
        #1;
        check("R1 async clear res", int'(res), 0);
        check("R1 async clear flag", int'(flag), 0);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        #3;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule